// File: doc/BRIEF.md
# Audio Sample FIFO Status and Interrupt Unit

This block holds the two sample queues of a serial audio controller: a transmit queue that the bus fills and the serial framer drains, and a receive queue that the serial framer fills and the bus drains. It reports on both queues in one 32-bit status word and raises one interrupt line. The status word carries the fill levels, not-empty and not-full indications, threshold service requests, a busy indication passed through from the framer, and sticky error flags for a receive overrun and a transmit underrun.

Software programs two service thresholds and an interrupt mask. It removes error flags by writing ones to a clear port. The service requests can be used directly as level requests by a DMA engine. The bit-clock and word-select shifting logic sits outside this block.

Top module: `aud_fifo_stat`

## Requirements
- R1: While reset is held and after it is released with `enable` low, `status` equals 32'h0000_0001 and `irq` is 0.
- R2: `status[15:12]` is the receive entry count and `status[11:8]` is the transmit entry count. Each is reported modulo 16, so a full 16-entry queue reads 0. `status[1]` is 1 when the receive queue is not empty and `status[0]` is 1 when the transmit queue is not full. `status[31:16]` and `status[7]` are 0.
- R3: Each queue returns samples in push order. Its read-data port shows the oldest entry without a pop, and shows 0 when the queue is empty.
- R4: A serial push (`rx_push`) into a full receive queue sets `status[6]` at the next edge. The sample is dropped and the stored samples are not changed.
- R5: A serial pop (`tx_pop`) from an empty transmit queue sets `status[5]` at the next edge. `tx_rdata` reads 0 and the queue pointers do not move.
- R6: A clock with `clr_wr` high clears `status[6]` when `clr_wdata[6]` is 1 and clears `status[5]` when `clr_wdata[5]` is 1. Other bits of `clr_wdata` have no effect. An error event in the same cycle keeps its flag set.
- R7: `status[4]` equals `enable` AND (receive count >= `rx_thresh`).
- R8: `status[3]` equals `enable` AND (transmit count <= `tx_thresh`).
- R9: `status[2]` equals `enable` AND `framer_busy`.
- R10: `irq` is a register loaded each clock with the OR of (`status[6:3]` AND `irq_mask[6:3]`). It therefore follows the status word one clock later, and mask bits outside 6:3 have no effect.
- R11: A bus push into a full transmit queue is dropped. A bus pop from an empty receive queue returns 0 and changes nothing. A push and a pop in the same cycle both take effect, judged against the fill at the start of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable |
| framer_busy | input | 1 | Serial framer is moving a frame |
| tx_push | input | 1 | Bus writes a transmit sample |
| tx_wdata | input | DW | Transmit sample from the bus |
| tx_pop | input | 1 | Framer takes a transmit sample |
| tx_rdata | output | DW | Oldest transmit sample (0 when empty) |
| rx_push | input | 1 | Framer delivers a receive sample |
| rx_wdata | input | DW | Receive sample from the framer |
| rx_pop | input | 1 | Bus takes a receive sample |
| rx_rdata | output | DW | Oldest receive sample (0 when empty) |
| tx_thresh | input | 4 | Transmit service threshold |
| rx_thresh | input | 4 | Receive service threshold |
| irq_mask | input | 32 | Interrupt mask, bits 6:3 used |
| clr_wr | input | 1 | Write strobe of the clear port |
| clr_wdata | input | 32 | Write-one-to-clear data, bits 6:5 used |
| status | output | 32 | Status word |
| irq | output | 1 | Combined interrupt request |

## Verification
Two pairs of actions can land in the same clock. An underrun event can coincide with a write to the clear port that targets the same flag, and a push can coincide with a pop on one queue. The bench provokes the first by pulsing `tx_pop` on the empty transmit queue while writing bit 5 to the clear port, and expects the flag to stay set. It provokes the second by pushing and popping together on a one-entry queue, and expects the level to stay at 1 with the new sample at the head.

// File: rtl/aud_fifo_pkg.sv
`timescale 1ns/1ps
package aud_fifo_pkg;
   localparam int unsigned ST_W     = 32;
   localparam int unsigned LVL_FLD  = 4;
   localparam int unsigned B_TNF    = 0;
   localparam int unsigned B_RNE    = 1;
   localparam int unsigned B_BSY    = 2;
   localparam int unsigned B_TSVC   = 3;
   localparam int unsigned B_RSVC   = 4;
   localparam int unsigned B_UNR    = 5;
   localparam int unsigned B_OVR    = 6;
   localparam int unsigned TXL_LSB  = 8;
   localparam int unsigned RXL_LSB  = 12;
   localparam logic [ST_W-1:0] IRQ_SRC = 32'h0000_0078;

   typedef struct packed {
      logic ovr;
      logic unr;
   } err_evt_t;
endpackage

// File: rtl/aud_fifo_buf.sv
`timescale 1ns/1ps
module aud_fifo_buf #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DW    = 16,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign count   = cnt;
   assign rdata   = empty ? '0 : mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/aud_err_flag.sv
`timescale 1ns/1ps
module aud_err_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= evt | (flag & ~clr);
   end
endmodule

// File: rtl/aud_svc_cmp.sv
`timescale 1ns/1ps
module aud_svc_cmp #(
   parameter int unsigned CW     = 5,
   parameter int unsigned TW     = 4,
   parameter bit          UPWARD = 1'b1
) (
   input  logic          en,
   input  logic [CW-1:0] cnt,
   input  logic [TW-1:0] thr,
   output logic          req
);
   localparam int unsigned MW = (CW > TW) ? CW : TW;
   logic [MW-1:0] cnt_x, thr_x;
   assign cnt_x = MW'(cnt);
   assign thr_x = MW'(thr);

   generate
      if (UPWARD) begin : g_at_or_above
         assign req = en && (cnt_x >= thr_x);
      end else begin : g_at_or_below
         assign req = en && (cnt_x <= thr_x);
      end
   endgenerate
endmodule

// File: rtl/aud_fifo_stat.sv
`timescale 1ns/1ps
module aud_fifo_stat
   import aud_fifo_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DW    = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          framer_busy,
   input  logic          tx_push,
   input  logic [DW-1:0] tx_wdata,
   input  logic          tx_pop,
   output logic [DW-1:0] tx_rdata,
   input  logic          rx_push,
   input  logic [DW-1:0] rx_wdata,
   input  logic          rx_pop,
   output logic [DW-1:0] rx_rdata,
   input  logic [3:0]    tx_thresh,
   input  logic [3:0]    rx_thresh,
   input  logic [31:0]   irq_mask,
   input  logic          clr_wr,
   input  logic [31:0]   clr_wdata,
   output logic [31:0]   status,
   output logic          irq
);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   initial begin : cfg_chk
      assert (DEPTH >= 2 && DEPTH <= 16 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("aud_fifo_stat: DEPTH must be a power of two in 2..16");
      assert (DW >= 1) else $error("aud_fifo_stat: DW must be at least 1");
   end

   logic [CW-1:0] tx_cnt, rx_cnt;
   logic          tx_full, tx_empty, rx_full, rx_empty;
   logic          tx_req, rx_req;
   logic          ovr_flag, unr_flag;
   err_evt_t      evt;
   logic [ST_W-1:0] st;
   logic          unused_clr_bits;

   assign unused_clr_bits = ^clr_wdata;

   aud_fifo_buf #(.DEPTH(DEPTH), .DW(DW)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_wdata),
      .pop(tx_pop), .rdata(tx_rdata), .count(tx_cnt),
      .full(tx_full), .empty(tx_empty));

   aud_fifo_buf #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_wdata),
      .pop(rx_pop), .rdata(rx_rdata), .count(rx_cnt),
      .full(rx_full), .empty(rx_empty));

   assign evt.ovr = rx_push && rx_full;
   assign evt.unr = tx_pop && tx_empty;

   aud_err_flag u_ovr (
      .clk(clk), .rst_n(rst_n), .evt(evt.ovr),
      .clr(clr_wr && clr_wdata[B_OVR]), .flag(ovr_flag));

   aud_err_flag u_unr (
      .clk(clk), .rst_n(rst_n), .evt(evt.unr),
      .clr(clr_wr && clr_wdata[B_UNR]), .flag(unr_flag));

   aud_svc_cmp #(.CW(CW), .TW(4), .UPWARD(1'b1)) u_rx_svc (
      .en(enable), .cnt(rx_cnt), .thr(rx_thresh), .req(rx_req));

   aud_svc_cmp #(.CW(CW), .TW(4), .UPWARD(1'b0)) u_tx_svc (
      .en(enable), .cnt(tx_cnt), .thr(tx_thresh), .req(tx_req));

   always_comb begin
      st                         = '0;
      st[RXL_LSB +: LVL_FLD]     = LVL_FLD'(rx_cnt);
      st[TXL_LSB +: LVL_FLD]     = LVL_FLD'(tx_cnt);
      st[B_OVR]                  = ovr_flag;
      st[B_UNR]                  = unr_flag;
      st[B_RSVC]                 = rx_req;
      st[B_TSVC]                 = tx_req;
      st[B_BSY]                  = enable && framer_busy;
      st[B_RNE]                  = !rx_empty;
      st[B_TNF]                  = !tx_full;
   end

   assign status = st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |(st & irq_mask & IRQ_SRC);
   end
endmodule

// File: rtl/aud_fifo_stat_chk.sv
`timescale 1ns/1ps
module aud_fifo_stat_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        enable,
   input logic        tx_pop,
   input logic        rx_push,
   input logic        clr_wr,
   input logic [31:0] clr_wdata,
   input logic [31:0] irq_mask,
   input logic [31:0] status,
   input logic        irq
);
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (status[31:16] == 16'h0) && !status[7]); // R2

   AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && status[1] && status[15:12] == 4'h0) |=> status[6]); // R4

   AST_UNR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_pop && status[0] && status[11:8] == 4'h0) |=> status[5]); // R5

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (status[6] && !(clr_wr && clr_wdata[6])) |=> status[6]); // R6

   AST_UNR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (status[5] && !(clr_wr && clr_wdata[5])) |=> status[5]); // R6

   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (status[4:2] == 3'b000)); // R7

   AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == |($past(status & irq_mask) & 32'h78))); // R10
endmodule

bind aud_fifo_stat aud_fifo_stat_chk chk_i (
   .clk(clk), .rst_n(rst_n), .enable(enable), .tx_pop(tx_pop),
   .rx_push(rx_push), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
   .irq_mask(irq_mask), .status(status), .irq(irq));

// File: tb/aud_fifo_stat_tb_top.sv
`timescale 1ns/1ps
module aud_fifo_stat_tb_top;
   logic        clk = 1'b0;
   logic        rst_n, enable, framer_busy;
   logic        tx_push, tx_pop, rx_push, rx_pop, clr_wr;
   logic [15:0] tx_wdata, rx_wdata, tx_rdata, rx_rdata;
   logic [3:0]  tx_thresh, rx_thresh;
   logic [31:0] irq_mask, clr_wdata, status;
   logic        irq;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   aud_fifo_stat dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .framer_busy(framer_busy),
      .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
      .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
      .tx_thresh(tx_thresh), .rx_thresh(rx_thresh), .irq_mask(irq_mask),
      .clr_wr(clr_wr), .clr_wdata(clr_wdata), .status(status), .irq(irq));

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      rst_n = 0; enable = 0; framer_busy = 0;
      tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; clr_wr = 0;
      tx_wdata = 0; rx_wdata = 0; tx_thresh = 0; rx_thresh = 0;
      irq_mask = 0; clr_wdata = 0;
      repeat (3) step();
      chk("R1 reset status", status, 32'h1);
      chk("R1 reset irq", irq, 0);
      rst_n = 1;
      step();
      chk("R1 after release", status, 32'h1);
      enable = 1;

      // transmit sweep: every level against every threshold
      for (int k = 0; k <= 16; k++) begin
         for (int th = 0; th < 16; th++) begin
            tx_thresh = th[3:0];
            #1;
            chk("R8 tx service", status[3], (k <= th) ? 1 : 0);
         end
         chk("R2 tx level", status[11:8], k % 16);
         chk("R2 tx not full", status[0], (k < 16) ? 1 : 0);
         if (k < 16) begin
            tx_push = 1; tx_wdata = 16'h0100 + 16'(k);
            step();
            tx_push = 0;
         end
      end
      tx_push = 1; tx_wdata = 16'hDEAD;
      step();
      tx_push = 0;
      chk("R11 tx drop level", status[11:8], 0);
      chk("R11 tx drop full", status[0], 0);
      for (int i = 0; i < 16; i++) begin
         chk("R3 tx order", tx_rdata, 16'h0100 + 16'(i));
         tx_pop = 1;
         step();
         tx_pop = 0;
      end
      chk("R5 no early underrun", status[5], 0);
      chk("R5 empty read zero", tx_rdata, 0);
      tx_pop = 1;
      step();
      tx_pop = 0;
      chk("R5 underrun set", status[5], 1);
      chk("R5 tx still empty", status[11:8], 0);
      tx_push = 1; tx_wdata = 16'h00AB;
      step();
      tx_push = 0;
      chk("R5 pointers kept", tx_rdata, 16'h00AB);
      tx_push = 1; tx_pop = 1; tx_wdata = 16'h00CD;
      step();
      tx_push = 0; tx_pop = 0;
      chk("R11 push+pop level", status[11:8], 1);
      chk("R11 push+pop head", tx_rdata, 16'h00CD);
      tx_pop = 1;
      step();
      tx_pop = 0;

      // receive sweep
      for (int k = 0; k <= 16; k++) begin
         for (int th = 0; th < 16; th++) begin
            rx_thresh = th[3:0];
            #1;
            chk("R7 rx service", status[4], (k >= th) ? 1 : 0);
         end
         chk("R2 rx level", status[15:12], k % 16);
         chk("R2 rx not empty", status[1], (k > 0) ? 1 : 0);
         if (k < 16) begin
            rx_push = 1; rx_wdata = 16'h0200 + 16'(k);
            step();
            rx_push = 0;
         end
      end
      chk("R4 no early overrun", status[6], 0);
      rx_push = 1; rx_wdata = 16'hBEEF;
      step();
      rx_push = 0;
      chk("R4 overrun set", status[6], 1);
      chk("R4 rx level kept", status[15:12], 0);
      for (int i = 0; i < 16; i++) begin
         chk("R4 R3 rx order", rx_rdata, 16'h0200 + 16'(i));
         rx_pop = 1;
         step();
         rx_pop = 0;
      end
      chk("R11 rx empty read", rx_rdata, 0);
      rx_pop = 1;
      step();
      rx_pop = 0;
      chk("R11 rx empty pop", status[15:12], 0);
      chk("R11 rx stays empty", status[1], 0);

      // clear port
      clr_wr = 1; clr_wdata = ~32'h60;
      step();
      chk("R6 other bits ignored", status[6:5], 2'b11);
      clr_wdata = 32'h40;
      step();
      chk("R6 clear overrun", status[6:5], 2'b01);
      clr_wdata = 32'h20; tx_pop = 1;
      step();
      tx_pop = 0;
      chk("R6 event beats clear", status[5], 1);
      step();
      clr_wr = 0; clr_wdata = 0;
      chk("R6 clear underrun", status[6:5], 2'b00);

      // busy and disable
      framer_busy = 1;
      #1 chk("R9 busy", status[2], 1);
      enable = 0; rx_thresh = 0; tx_thresh = 15;
      #1;
      chk("R7 disabled rx req", status[4], 0);
      chk("R8 disabled tx req", status[3], 0);
      chk("R9 disabled busy", status[2], 0);
      enable = 1;
      #1 chk("R7 R8 R9 enabled", status[4:2], 3'b111);
      step();

      // interrupt timing and masking
      irq_mask = 32'h08;
      #1 chk("R10 irq not yet", irq, 0);
      step();
      chk("R10 irq one clock later", irq, 1);
      enable = 0;
      #1 chk("R10 irq held", irq, 1);
      step();
      chk("R10 irq drops", irq, 0);
      enable = 1; irq_mask = ~32'h78; tx_thresh = 0; rx_thresh = 1;
      tx_push = 1; tx_wdata = 16'h0011;
      step();
      tx_push = 0;
      step();
      chk("R10 outside mask ignored", irq, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule